// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block sits on the host side of a parallel EPROM socket and writes a byte image into an erased device. It fetches each image byte from a synchronous byte source. It reads the device location first and refuses to program if the image wants a bit set that is already zero. It then gives short program pulses of fixed width, reading the location back after each one. It stops pulsing as soon as the byte reads back correctly, or gives up once a pulse budget is spent.

Image bytes equal to all ones need no programming, so they are passed over during the programming pass. After the last address the sequencer drops the programming supply and returns the device supply to its nominal read level. It then runs a second pass that reads every location and compares it with the image. Any failure stops the run with a flag naming its cause and the address where it happened. A new start pulse restarts the run from address zero.

The block only commands the supply levels through two enable outputs. The analog supplies themselves are generated elsewhere.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, and while no run is active, ceN and oeN are 1, vppEn, vccProg and devDataOe are 0, and busy, done and all three fail flags are 0.
- R2: A program pulse holds ceN=0 and oeN=1 with vppEn=1, vccProg=1 and devDataOe=1, driving the image byte on devDataOut. It lasts exactly (CLK_HZ/1000)*PULSE_US/1000 clock cycles, which is 5 cycles with CLK_HZ=50000 and PULSE_US=100.
- R3: After every pulse the location is read back with ceN=0, oeN=0, devDataOe=0 and the programming supplies still on. Pulsing at that address stops at the first read that matches, so an address needing k pulses (k <= MAX_PULSES) receives exactly k.
- R4: If the read after pulse number MAX_PULSES still mismatches, failPulses rises, failAddr holds that address, the run stops with every device control inactive, and no further pulse is given.
- R5: Before any pulse, the location is read. If the image byte has a 1 where the device holds a 0, failConflict rises with failAddr set, and that address gets no pulse.
- R6: A location that already reads back equal to its image byte receives no pulse.
- R7: An image byte of all ones (0xFF) is neither read nor pulsed during the programming pass.
- R8: After the last address, vppEn and vccProg fall to 0, and every address from 0 upward is read with ceN=0 and oeN=0 and compared with the image. When all match, done rises with vppEn=0 and vccProg=0.
- R9: A mismatch in the final pass, including at a location whose image byte is 0xFF, raises failVerify with failAddr at that address. No later address is read.
- R10: The image is read through addr: srcData is sampled on the second rising clock edge after addr takes a new value, which suits a source memory with one cycle of read latency.
- R11: At most one fail flag is high at a time. A fail flag and failAddr hold until the next start, and start clears them and restarts the run at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command that starts a run from address 0 |
| addr | output | ADDR_W | Address shared by the image source and the device |
| srcData | input | DATA_W | Image byte for addr, valid one cycle after addr changes |
| devDataIn | input | DATA_W | Data read from the device |
| devDataOut | output | DATA_W | Data driven to the device during a pulse |
| devDataOe | output | 1 | Host drives the device data pins when 1 |
| ceN | output | 1 | Device chip enable, active low; low with oeN high is a program pulse |
| oeN | output | 1 | Device output enable, active low |
| vppEn | output | 1 | Requests the programming voltage on the device program supply |
| vccProg | output | 1 | Selects the raised device supply used while programming |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run ended with every location verified |
| failConflict | output | 1 | The image asked for a zero bit to become one |
| failPulses | output | 1 | The pulse budget was exhausted at an address |
| failVerify | output | 1 | The final pass found a mismatch |
| failAddr | output | ADDR_W | Address of the failure |

## Verification
A device model counts the pulses each location receives and only takes the new byte after a set number of pulses per address, so the programming pass is tried with addresses needing one, two, three and exactly the maximum number of pulses. That separates stopping at the first matching read from over-pulsing or from giving up one pulse early. Further images put a pre-zeroed bit under a one, an uncooperative cell that never programs, a location already holding its byte, and a pre-programmed location under an all-ones image byte. These exercise the conflict check, the pulse cap, the zero-pulse path and the fact that skipped bytes are still caught in the final pass. Read counts, split by supply setting, show which pass touched each address.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LATCH, S_PRERD, S_PULSE, S_RECOVER, S_VFYRD, S_NEXT,
    S_SWITCH, S_FFETCH, S_FLATCH, S_FRD, S_FNEXT, S_DONE, S_FAIL
  } seqState_t;

  typedef enum logic [1:0] {
    FK_NONE, FK_CONFLICT, FK_PULSES, FK_VERIFY
  } failKind_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic runClr;
    logic addrClr;
    logic addrInc;
    logic tgtLoad;
    logic cntClr;
    logic cntInc;
    logic tmrPulse;
    logic tmrRead;
    logic tmrSettle;
    logic failCap;
  } ctlStrobes_t;

endpackage

// File: rtl/eprom_prog_dp.sv
module eprom_prog_dp
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 25,
  parameter int PULSE_CYC  = 5000,
  parameter int READ_CYC   = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] target,
  output logic [ADDR_W-1:0] failAddr,
  output logic              srcBlank,
  output logic              match,
  output logic              conflict,
  output logic              cntMax,
  output logic              tmrDone,
  output logic              lastAddr
);

  localparam int TMR_MAX01 = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
  localparam int TMR_MAX   = (TMR_MAX01 > SETTLE_CYC) ? TMR_MAX01 : SETTLE_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int CNT_W     = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [DATA_W-1:0] BLANK     = '1;

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] pulseCnt;
  logic [DATA_W-1:0] zeroUnder;

  // address counter, shared by the image source and the device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 addr <= '0;
    else if (strobes.runClr || strobes.addrClr) addr <= '0;
    else if (strobes.addrInc)                   addr <= addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                target <= BLANK;
    else if (strobes.tgtLoad) target <= srcData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobes.cntClr)  pulseCnt <= '0;
    else if (strobes.cntInc)  pulseCnt <= pulseCnt + 1'b1;
  end

  // one down-counter times pulses, reads and the supply settle wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tmr <= '0;
    else if (strobes.tmrPulse)  tmr <= TMR_W'(PULSE_CYC - 1);
    else if (strobes.tmrRead)   tmr <= TMR_W'(READ_CYC - 1);
    else if (strobes.tmrSettle) tmr <= TMR_W'(SETTLE_CYC - 1);
    else if (tmr != '0)         tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                failAddr <= '0;
    else if (strobes.runClr)  failAddr <= '0;
    else if (strobes.failCap) failAddr <= addr;
  end

  // per-bit test: the image wants a one where the cell already holds zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_conflict
    assign zeroUnder[b] = target[b] & ~devDataIn[b];
  end

  assign srcBlank = (srcData == BLANK);
  assign match    = (devDataIn == target);
  assign conflict = |zeroUnder;
  assign cntMax   = (pulseCnt >= CNT_W'(MAX_PULSES));
  assign tmrDone  = (tmr == '0);
  assign lastAddr = (addr == ADDR_LAST);

endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
  import eprom_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        srcBlank,
  input  logic        match,
  input  logic        conflict,
  input  logic        cntMax,
  input  logic        tmrDone,
  input  logic        lastAddr,
  output ctlStrobes_t strobes,
  output logic        ceN,
  output logic        oeN,
  output logic        vppEn,
  output logic        vccProg,
  output logic        dataOe,
  output logic        busy,
  output logic        done,
  output logic        failConflict,
  output logic        failPulses,
  output logic        failVerify
);

  seqState_t state, stateNxt;
  failKind_t failKind, kindNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      failKind <= FK_NONE;
    end else begin
      state <= stateNxt;
      if (strobes.runClr)       failKind <= FK_NONE;
      else if (strobes.failCap) failKind <= kindNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    kindNxt  = FK_NONE;
    strobes  = '0;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          strobes.runClr = 1'b1;
          stateNxt       = S_FETCH;
        end
      end
      S_FETCH: stateNxt = S_LATCH;
      S_LATCH: begin
        strobes.tgtLoad = 1'b1;
        strobes.cntClr  = 1'b1;
        if (srcBlank) begin
          stateNxt = S_NEXT;
        end else begin
          strobes.tmrRead = 1'b1;
          stateNxt        = S_PRERD;
        end
      end
      S_PRERD: begin
        if (tmrDone) begin
          if (conflict) begin
            strobes.failCap = 1'b1;
            kindNxt         = FK_CONFLICT;
            stateNxt        = S_FAIL;
          end else if (match) begin
            stateNxt = S_NEXT;
          end else begin
            strobes.tmrPulse = 1'b1;
            stateNxt         = S_PULSE;
          end
        end
      end
      S_PULSE: begin
        if (tmrDone) begin
          strobes.cntInc = 1'b1;
          stateNxt       = S_RECOVER;
        end
      end
      S_RECOVER: begin
        strobes.tmrRead = 1'b1;
        stateNxt        = S_VFYRD;
      end
      S_VFYRD: begin
        if (tmrDone) begin
          if (match) begin
            stateNxt = S_NEXT;
          end else if (cntMax) begin
            strobes.failCap = 1'b1;
            kindNxt         = FK_PULSES;
            stateNxt        = S_FAIL;
          end else begin
            strobes.tmrPulse = 1'b1;
            stateNxt         = S_PULSE;
          end
        end
      end
      S_NEXT: begin
        if (lastAddr) begin
          strobes.addrClr   = 1'b1;
          strobes.tmrSettle = 1'b1;
          stateNxt          = S_SWITCH;
        end else begin
          strobes.addrInc = 1'b1;
          stateNxt        = S_FETCH;
        end
      end
      S_SWITCH: if (tmrDone) stateNxt = S_FFETCH;
      S_FFETCH: stateNxt = S_FLATCH;
      S_FLATCH: begin
        strobes.tgtLoad = 1'b1;
        strobes.tmrRead = 1'b1;
        stateNxt        = S_FRD;
      end
      S_FRD: begin
        if (tmrDone) begin
          if (match) begin
            stateNxt = S_FNEXT;
          end else begin
            strobes.failCap = 1'b1;
            kindNxt         = FK_VERIFY;
            stateNxt        = S_FAIL;
          end
        end
      end
      S_FNEXT: begin
        if (lastAddr) begin
          stateNxt = S_DONE;
        end else begin
          strobes.addrInc = 1'b1;
          stateNxt        = S_FFETCH;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  // device control decode from the state register
  always_comb begin
    ceN     = 1'b1;
    oeN     = 1'b1;
    dataOe  = 1'b0;
    vppEn   = 1'b0;
    vccProg = 1'b0;
    unique case (state)
      S_PRERD, S_VFYRD: begin
        ceN = 1'b0;
        oeN = 1'b0;
      end
      S_PULSE: begin
        ceN    = 1'b0;
        dataOe = 1'b1;
      end
      S_FRD: begin
        ceN = 1'b0;
        oeN = 1'b0;
      end
      default: ;
    endcase
    unique case (state)
      S_FETCH, S_LATCH, S_PRERD, S_PULSE, S_RECOVER, S_VFYRD, S_NEXT: begin
        vppEn   = 1'b1;
        vccProg = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy         = !(state inside {S_IDLE, S_DONE, S_FAIL});
  assign done         = (state == S_DONE);
  assign failConflict = (state == S_FAIL) && (failKind == FK_CONFLICT);
  assign failPulses   = (state == S_FAIL) && (failKind == FK_PULSES);
  assign failVerify   = (state == S_FAIL) && (failKind == FK_VERIFY);

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int READ_CYC   = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe,
  output logic              ceN,
  output logic              oeN,
  output logic              vppEn,
  output logic              vccProg,
  output logic              busy,
  output logic              done,
  output logic              failConflict,
  output logic              failPulses,
  output logic              failVerify,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int PULSE_RAW = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

  ctlStrobes_t strobes;
  logic srcBlank, match, conflict, cntMax, tmrDone, lastAddr;

  eprom_prog_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .srcBlank     (srcBlank),
    .match        (match),
    .conflict     (conflict),
    .cntMax       (cntMax),
    .tmrDone      (tmrDone),
    .lastAddr     (lastAddr),
    .strobes      (strobes),
    .ceN          (ceN),
    .oeN          (oeN),
    .vppEn        (vppEn),
    .vccProg      (vccProg),
    .dataOe       (devDataOe),
    .busy         (busy),
    .done         (done),
    .failConflict (failConflict),
    .failPulses   (failPulses),
    .failVerify   (failVerify)
  );

  eprom_prog_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_PULSES (MAX_PULSES),
    .PULSE_CYC  (PULSE_CYC),
    .READ_CYC   (READ_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcData   (srcData),
    .devDataIn (devDataIn),
    .addr      (addr),
    .target    (devDataOut),
    .failAddr  (failAddr),
    .srcBlank  (srcBlank),
    .match     (match),
    .conflict  (conflict),
    .cntMax    (cntMax),
    .tmrDone   (tmrDone),
    .lastAddr  (lastAddr)
  );

endmodule

// File: rtl/eprom_prog_chk.sv
module eprom_prog_chk #(
  parameter int ADDR_W    = 15,
  parameter int PULSE_CYC = 5000
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              ceN,
  input logic              oeN,
  input logic              devDataOe,
  input logic              vppEn,
  input logic              vccProg,
  input logic              busy,
  input logic              done,
  input logic              failConflict,
  input logic              failPulses,
  input logic              failVerify,
  input logic [ADDR_W-1:0] failAddr
);

  int lowCnt;
  logic anyFail;

  assign anyFail = failConflict | failPulses | failVerify;

  // length of the current program pulse, counted at the ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= 0;
    else if (!ceN && oeN)   lowCnt <= lowCnt + 1;
    else                    lowCnt <= 0;
  end

  AST_PULSE_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |-> (vppEn && vccProg && devDataOe)); // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && lowCnt != 0) |-> (lowCnt == PULSE_CYC)); // R2

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN) |-> (!devDataOe && !ceN)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |-> (ceN && oeN && !devDataOe && !vppEn && !vccProg)); // R1

  AST_DONE_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!vppEn && !vccProg && !anyFail)); // R8

  AST_FAIL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({failConflict, failPulses, failVerify})); // R11

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (anyFail && !start) |=> (anyFail && $stable(failAddr))); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!anyFail && busy)); // R11

endmodule

bind eprom_prog_seq eprom_prog_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .ceN          (ceN),
  .oeN          (oeN),
  .devDataOe    (devDataOe),
  .vppEn        (vppEn),
  .vccProg      (vccProg),
  .busy         (busy),
  .done         (done),
  .failConflict (failConflict),
  .failPulses   (failPulses),
  .failVerify   (failVerify),
  .failAddr     (failAddr)
);

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW     = 3;
  localparam int N      = 1 << AW;
  localparam int CLKHZ  = 50_000;
  localparam int PUS    = 100;
  localparam int PW     = 5;   // expected pulse width in cycles
  localparam int MAXP   = 4;
  localparam int RDC    = 2;
  localparam int STC    = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr;
  logic [7:0] srcData;
  logic [7:0] devDataIn;
  logic [7:0] devDataOut;
  logic devDataOe, ceN, oeN, vppEn, vccProg, busy, done;
  logic failConflict, failPulses, failVerify;
  logic [AW-1:0] failAddr;

  int errors = 0;
  int checks = 0;

  // stimulus-side data, written only by the initial block
  logic [7:0] image  [N];
  logic [7:0] preset [N];
  int         need   [N];
  logic       loadReq = 1'b0;

  // device model state, written only by the model block
  logic [7:0] mem        [N];
  int         hits       [N];
  int         progReads  [N];
  int         finalReads [N];
  int         widthCnt, widthBad;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(8), .CLK_HZ(CLKHZ), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .READ_CYC(RDC), .SETTLE_CYC(STC)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .srcData(srcData),
    .devDataIn(devDataIn), .devDataOut(devDataOut), .devDataOe(devDataOe),
    .ceN(ceN), .oeN(oeN), .vppEn(vppEn), .vccProg(vccProg), .busy(busy),
    .done(done), .failConflict(failConflict), .failPulses(failPulses),
    .failVerify(failVerify), .failAddr(failAddr)
  );

  // image source with one cycle of read latency
  always @(posedge clk) srcData <= image[addr];

  assign devDataIn = (!ceN && !oeN) ? mem[addr] : 8'hFF;

  // device model: a cell takes the byte only after need[] pulses
  always @(posedge clk) begin
    if (loadReq) begin
      for (int i = 0; i < N; i++) begin
        mem[i] <= preset[i];
        hits[i] <= 0;
        progReads[i] <= 0;
        finalReads[i] <= 0;
      end
      widthCnt <= 0;
      widthBad <= 0;
    end else begin
      if (!ceN && oeN && vppEn && vccProg && devDataOe) begin
        widthCnt <= widthCnt + 1;
      end else if (widthCnt != 0) begin
        hits[addr] <= hits[addr] + 1;
        if (widthCnt != PW) widthBad <= widthBad + 1;
        if (hits[addr] + 1 >= need[addr]) mem[addr] <= mem[addr] & devDataOut;
        widthCnt <= 0;
      end
      if (!ceN && !oeN) begin
        if (vppEn && vccProg) progReads[addr] <= progReads[addr] + 1;
        else if (!vppEn && !vccProg) finalReads[addr] <= finalReads[addr] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic setup(input logic [7:0] img [N], input logic [7:0] pre [N], input int nd [N]);
    for (int i = 0; i < N; i++) begin
      image[i] = img[i];
      preset[i] = pre[i];
      need[i] = nd[i];
    end
    @(negedge clk) loadReq = 1'b1;
    @(negedge clk) loadReq = 1'b0;
  endtask

  // pulse start, confirm the restart, wait for the run to end
  task automatic run(input string tag);
    bit ended;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !failConflict && !failPulses && !failVerify,
        {"R11 start clears flags ", tag}, int'(busy), 1);
    ended = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done || failConflict || failPulses || failVerify) begin
        ended = 1'b1;
        break;
      end
    end
    chk(ended, {"R8 run ends ", tag}, int'(ended), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ceN && oeN, "R1 reset ceN/oeN", int'({ceN, oeN}), 3);
    chk(!vppEn && !vccProg && !devDataOe, "R1 reset supplies/bus",
        int'({vppEn, vccProg, devDataOe}), 0);
    chk(!busy && !done && !failConflict && !failPulses && !failVerify,
        "R1 reset status", int'({busy, done, failConflict, failPulses, failVerify}), 0);
  endtask

  task automatic t_normal();
    logic [7:0] img [N] = '{8'h00, 8'hA5, 8'hFF, 8'h3C, 8'h7E, 8'hFF, 8'h81, 8'h12};
    logic [7:0] pre [N] = '{default: 8'hFF};
    int nd [N] = '{1, 2, 1, 3, MAXP, 1, 2, 1};
    setup(img, pre, nd);
    run("normal");
    chk(done && !failPulses && !failConflict && !failVerify, "R8 done flag", int'(done), 1);
    chk(!vppEn && !vccProg && ceN && oeN, "R8 nominal supplies at end",
        int'({vppEn, vccProg}), 0);
    chk(widthBad == 0, "R2 pulse width", widthBad, 0);
    for (int i = 0; i < N; i++) begin
      chk(mem[i] == img[i], $sformatf("R10 byte at %0d", i), mem[i], img[i]);
      if (img[i] == 8'hFF) begin
        chk(hits[i] == 0 && progReads[i] == 0, $sformatf("R7 skipped %0d", i),
            hits[i] + progReads[i], 0);
      end else begin
        chk(hits[i] == nd[i], $sformatf("R3 pulses at %0d", i), hits[i], nd[i]);
        chk(progReads[i] > hits[i], $sformatf("R3 reads at %0d", i), progReads[i], hits[i] + 1);
      end
      chk(finalReads[i] > 0, $sformatf("R8 final read %0d", i), finalReads[i], 1);
    end
  endtask

  task automatic t_conflict();
    logic [7:0] img [N] = '{8'h55, 8'hFF, 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    logic [7:0] pre [N] = '{8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    int nd [N] = '{default: 1};
    setup(img, pre, nd);
    run("conflict");
    chk(failConflict && !failPulses && !failVerify, "R5 conflict flag", int'(failConflict), 1);
    chk(failAddr == 3'd2, "R5 conflict addr", failAddr, 2);
    chk(hits[2] == 0, "R5 no pulse on conflict", hits[2], 0);
    chk(mem[0] == 8'h55, "R5 earlier byte written", mem[0], 8'h55);
    chk(hits[7] == 0, "R5 stopped after conflict", hits[7], 0);
  endtask

  task automatic t_cap();
    logic [7:0] img [N] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h11, 8'hFF};
    logic [7:0] pre [N] = '{default: 8'hFF};
    int nd [N] = '{1, 1, 1, 1, 1, 99, 1, 1};
    setup(img, pre, nd);
    run("cap");
    chk(failPulses && !failConflict && !failVerify, "R4 pulse cap flag", int'(failPulses), 1);
    chk(failAddr == 3'd5, "R4 cap addr", failAddr, 5);
    chk(hits[5] == MAXP, "R4 pulses at cap", hits[5], MAXP);
    chk(ceN && oeN && !vppEn && !devDataOe, "R4 controls idle", int'({ceN, oeN}), 3);
    repeat (20) @(negedge clk);
    chk(hits[5] == MAXP && hits[6] == 0, "R4 no pulse after cap", hits[5] + hits[6], MAXP);
    chk(failPulses && failAddr == 3'd5, "R11 flag held", int'(failPulses), 1);
  endtask

  task automatic t_verify_fail();
    logic [7:0] img [N] = '{default: 8'hFF};
    logic [7:0] pre [N] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'hFF};
    int nd [N] = '{default: 1};
    setup(img, pre, nd);
    run("verify");
    chk(failVerify && !failPulses && !failConflict, "R9 verify flag", int'(failVerify), 1);
    chk(failAddr == 3'd6, "R9 verify addr", failAddr, 6);
    chk(progReads[6] == 0 && finalReads[6] > 0, "R9 blank checked only at end",
        progReads[6], 0);
    chk(finalReads[7] == 0, "R9 stop after mismatch", finalReads[7], 0);
  endtask

  task automatic t_already();
    logic [7:0] img [N] = '{8'hFF, 8'h33, 8'hFF, 8'h44, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] pre [N] = '{8'hFF, 8'h33, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    int nd [N] = '{default: 1};
    setup(img, pre, nd);
    run("already");
    chk(done, "R6 done", int'(done), 1);
    chk(hits[1] == 0 && progReads[1] > 0, "R6 no pulse on equal byte", hits[1], 0);
    chk(hits[3] == 1 && mem[3] == 8'h44, "R3 single pulse", hits[3], 1);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      image[i] = 8'hFF;
      preset[i] = 8'hFF;
      need[i] = 1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_conflict();
    t_cap();
    t_verify_fail();
    t_already();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule